// File: doc/BRIEF.md
# Alert Source Address Latch

Several devices on a shared alert line can ask for service at the same time. This block keeps one pending flag for every 7-bit device address. When an alert arrives for an address, the flag for that address is set. The block then loads one of these addresses into an 8-bit holding register, which firmware reads over a simple host port. The address sits in the upper seven bits of the register.

The register takes a new address only while it reads zero. If several flags are set, the smallest address is loaded first, and its flag is cleared once it is loaded. Firmware writes zero to the register after it has serviced the device. The block then loads the next pending address. Any host write that is not zero has no effect.

Address zero is not used as a device address, because a register value of zero means that nothing is captured. An `alert_valid` output is high whenever the register holds an address.

Top module: `alert_addr_latch`

## Requirements
- R1: The read port `host_rdata` presents the captured device address in bits [7:1], and bit 0 always reads 0. For example, address 0x25 reads as 0x4A.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `host_rdata` is 0x00 and `alert_valid` is 0.
- R3: While the register is nonzero, its value is held. Alerts that arrive during this time are stored as pending and are not lost.
- R4: When several addresses are pending, the smallest address is loaded first. The others follow in ascending order, one after each clear.
- R5: Timing of a capture:
  - A bit of `alert_set` that is high at a clock edge makes that address pending at that edge.
  - A pending address is loaded at the next edge, and only if the register is zero at that edge.
  - After a clear, the next pending address is loaded one cycle later.
- R6: `alert_valid` is 1 exactly when the register is nonzero.
- R7: A host write (`host_wr` = 1) with any nonzero data leaves the register unchanged.
- R8: An alert on source index 0 is ignored and never produces a capture.
- R9: A host write of 0x00 clears the register at that edge. If that edge would also load a pending address, the clear takes effect instead. The pending address is loaded at the following edge.
- R10: Loading an address retires its pending flag. Once that address has been cleared, it is not loaded again unless a new alert arrives for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alert_set | input | 128 | One alert strobe per device address; bit i stands for address i |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data; only 0x00 has an effect |
| host_rdata | output | 8 | Holding register: address in [7:1], bit 0 is 0 |
| alert_valid | output | 1 | High while the register is nonzero |

## Verification
Two functions can fall in the same cycle: the host clear and the loading of a pending address. The bench sets this up in three steps. First it holds an address in the register while a second address is pending. It then writes 0x00 and keeps the write active for one more cycle, so the second clear lands while the register is empty and a pending flag is present. The bench passes this case if the register still reads zero after that edge and the pending address appears one cycle later. A scoreboard compares each expected register value against the read port, sampled half a cycle after the edge that produced it.

// File: rtl/alert_pkg.sv
// Package: shared sizes and types for the alert source address latch.
// Assumes 7-bit device addresses, with one pending flag per address.
package alert_pkg;
    localparam int ADDR_W = 7;
    localparam int NUM_SRC = 1 << ADDR_W;
    localparam int REG_W = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] dev_addr_t;
    typedef logic [REG_W-1:0]  host_word_t;
endpackage

// File: rtl/pending_store.sv
// Module: pending_store
// Keeps one pending flag per source. A set strobe raises the flag. A retire
// strobe with an index lowers that flag. If a set and a retire hit the same
// bit in the same cycle, the set wins, so a fresh alert is never dropped.
// Assumes that source 0 is not a device, so its flag is kept at zero.
module pending_store #(
    parameter int NSRC = 128,
    parameter int AW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_in,
    input  logic            retire_en,
    input  logic [AW-1:0]   retire_idx,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] pend_d;

    // Next-state value of each pending flag.
    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        if (g == 0) begin : g_null
            assign pend_d[g] = 1'b0;
        end else begin : g_dev
            logic hit;
            assign hit       = retire_en && (retire_idx == AW'(g));
            assign pend_d[g] = (pend_q[g] && !hit) || set_in[g];
        end
    end

    // Register the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R10
    retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_en && !set_in[retire_idx]) |=> !pend_q[$past(retire_idx)]);

    // R8
    src0_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_in[0] |=> !pend_q[0]);
endmodule

// File: rtl/lowest_pick.sv
// Module: lowest_pick
// Finds the lowest set bit of the pending vector and returns its index.
// A chain built by generate marks the first set bit, and an OR-reduction
// encodes its index. clk and rst_n are used only by the assertions.
module lowest_pick #(
    parameter int NSRC = 128,
    parameter int AW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [AW-1:0]   idx
);
    logic [NSRC-1:0] seen;
    logic [NSRC-1:0] first;

    // Mark the first set bit, scanning from index 0 upward.
    for (genvar g = 0; g < NSRC; g++) begin : g_scan
        if (g == 0) begin : g_lo
            assign seen[g]  = pend[g];
            assign first[g] = pend[g];
        end else begin : g_up
            assign seen[g]  = seen[g-1] | pend[g];
            assign first[g] = pend[g] & ~seen[g-1];
        end
    end

    assign any = seen[NSRC-1];

    // Encode the one-hot first bit as a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first[i]) idx = idx | AW'(i);
        end
    end

    // R4
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first));

    // R4
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> pend[idx]);
endmodule

// File: rtl/addr_hold.sv
// Module: addr_hold
// Holding register for the captured address, together with its host port.
// A host write of zero clears the register, and this takes priority over a
// capture. A capture happens only when the register is empty and no clear
// is active. Assumes that a picked index is never zero.
module addr_hold #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [AW:0]   host_wdata,
    input  logic          cand_any,
    input  logic [AW-1:0] cand_idx,
    output logic          take,
    output logic [AW:0]   host_rdata,
    output logic          alert_valid
);
    logic [AW-1:0] addr_q;
    logic          clear_req;
    logic          empty;

    // Decode a clear write and the capture condition.
    always_comb begin
        clear_req = host_wr && (host_wdata == '0);
        empty     = (addr_q == '0);
        take      = empty && !clear_req && cand_any;
    end

    // Update the stored address: a clear first, then a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (clear_req) addr_q <= '0;
        else if (take)      addr_q <= cand_idx;
    end

    // Drive the read port and the valid flag.
    assign host_rdata  = {addr_q, 1'b0};
    assign alert_valid = |addr_q;

    // R3
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !clear_req) |=> $stable(addr_q));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (host_rdata == '0));

    // R5
    load_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(addr_q) && addr_q != '0) |-> ($past(addr_q) == '0));

    // R7
    nonzero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata != '0 && !empty) |=> $stable(host_rdata));
endmodule

// File: rtl/alert_addr_latch.sv
// Module: alert_addr_latch (top)
// Latches the lowest pending alert source address into a host-readable
// register. Per-address alert strobes set pending flags. Each capture
// retires its flag. A host write of zero releases the register so that the
// next address can be loaded.
module alert_addr_latch #(
    parameter int AW   = alert_pkg::ADDR_W,
    parameter int NSRC = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] alert_set,
    input  logic            host_wr,
    input  logic [AW:0]     host_wdata,
    output logic [AW:0]     host_rdata,
    output logic            alert_valid
);
    logic [NSRC-1:0] pend_q;
    logic            cand_any;
    logic [AW-1:0]   cand_idx;
    logic            take;

    pending_store #(.NSRC(NSRC), .AW(AW)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_in(alert_set),
        .retire_en(take), .retire_idx(cand_idx), .pend_q(pend_q)
    );

    lowest_pick #(.NSRC(NSRC), .AW(AW)) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(pend_q),
        .any(cand_any), .idx(cand_idx)
    );

    addr_hold #(.AW(AW)) u_hold (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .cand_any(cand_any), .cand_idx(cand_idx), .take(take),
        .host_rdata(host_rdata), .alert_valid(alert_valid)
    );

    // R6
    valid_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_valid == (host_rdata != '0));

    // R1
    low_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[0] == 1'b0);
endmodule

// File: tb/alert_addr_latch_tb_top.sv
// Scoreboard bench: the driver pushes expected register values, and a
// monitor pops them and compares them at each falling edge.
module alert_addr_latch_tb_top;
    localparam int AW = 7;
    localparam int NS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] alert_set = '0;
    logic          host_wr = 1'b0;
    logic [AW:0]   host_wdata = '0;
    logic [AW:0]   host_rdata;
    logic          alert_valid;

    always #2 clk = ~clk;

    alert_addr_latch dut_i (
        .clk(clk), .rst_n(rst_n), .alert_set(alert_set),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .alert_valid(alert_valid)
    );

    typedef struct {
        logic [AW:0] rd;
        logic        vl;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input logic [AW:0] rd, input string tag);
        item_t it;
        it.rd  = rd;
        it.vl  = (rd != '0);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pulse();
        tick();
        alert_set = '0;
    endtask

    task automatic wr(input logic [AW:0] d);
        host_wr    = 1'b1;
        host_wdata = d;
        tick();
        host_wr    = 1'b0;
        host_wdata = '0;
    endtask

    // Monitor: compares each queued expectation against the ports.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (host_rdata !== it.rd || alert_valid !== it.vl) begin
                errors++;
                $display("FAIL %s: rdata=%h valid=%b expected rdata=%h valid=%b",
                         it.tag, host_rdata, alert_valid, it.rd, it.vl);
            end
        end
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) tick();
        expect_now(8'h00, "R2 in reset");
        rst_n = 1'b1;
        tick();
        expect_now(8'h00, "R2 after reset");

        // Single alert; R1 field layout and R6 valid flag.
        alert_set[7'h25] = 1'b1;
        pulse();
        expect_now(8'h00, "R5 pending, not yet loaded");
        tick();
        expect_now(8'h4A, "R1 R6 address 0x25 loaded");

        // R3: a new alert while the register is held.
        alert_set[7'h03] = 1'b1;
        pulse();
        tick();
        expect_now(8'h4A, "R3 held while nonzero");

        // R7: a nonzero write is ignored.
        wr(8'h55);
        expect_now(8'h4A, "R7 nonzero write ignored");

        // R5: clear, then the next pending address is loaded.
        wr(8'h00);
        expect_now(8'h00, "R5 cleared");
        tick();
        expect_now(8'h06, "R5 next pending loaded");
        wr(8'h00);
        tick();
        expect_now(8'h00, "R10 no duplicate capture");

        // R8: source index 0 is ignored.
        alert_set[0] = 1'b1;
        pulse();
        tick();
        tick();
        expect_now(8'h00, "R8 source 0 ignored");

        // R4: simultaneous alerts are served in ascending order.
        alert_set[7'h40] = 1'b1;
        alert_set[7'h11] = 1'b1;
        alert_set[7'h7F] = 1'b1;
        pulse();
        tick();
        expect_now(8'h22, "R4 lowest first");
        wr(8'h00);
        tick();
        expect_now(8'h80, "R4 second lowest");
        wr(8'h00);
        tick();
        expect_now(8'hFE, "R4 highest last");
        wr(8'h00);
        tick();
        expect_now(8'h00, "R10 all retired");

        // R9: a clear and a capture in the same cycle.
        alert_set[7'h30] = 1'b1;
        pulse();
        tick();
        expect_now(8'h60, "R9 setup holds 0x30");
        alert_set[7'h05] = 1'b1;
        pulse();
        tick();
        expect_now(8'h60, "R3 held with 0x05 pending");
        host_wr    = 1'b1;
        host_wdata = 8'h00;
        tick();
        expect_now(8'h00, "R9 first clear");
        tick();
        expect_now(8'h00, "R9 clear wins over capture");
        host_wr = 1'b0;
        tick();
        expect_now(8'h0A, "R9 capture resumes next cycle");
        wr(8'h00);
        tick();
        expect_now(8'h00, "R10 final empty");

        tick();
        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule